// File: doc/BRIEF.md
# Per-Net Pending Event Filter

This block keeps the pending output-change events of a single gate output inside a hardware event-driven logic simulator. A gate evaluator offers a new event as an evaluation time and a three-state value. The block adds the configured propagation delay to get the event time. It then compares the event with the net's settled value and with the pending events next to it. From that it decides whether to keep the event, discard it, or cancel pending events that have become obsolete. With a non-zero inertial delay, short glitches are removed as well.

The pending events are held in a small list sorted by time. When the global simulation time input matches the time of the head event, the block offers that event. A pop commits its value as the net's settled value and moves the rest of the list up. At most one insert is handled per clock. Its verdict appears one cycle later on registered result outputs.

Occupancy is tracked by a three-state controller with these states: EMPTY (no pending events), PARTIAL (some slots used) and FULL (every slot used). The transitions are named as follows. EMPTY→PARTIAL happens on an insert. PARTIAL→FULL happens on an insert into the last free slot. PARTIAL→EMPTY happens when a pop or cancel removes the only entry. FULL→PARTIAL happens on a pop or cancel. Every other case holds the current state.

Top module: `evf_net_filter`

## Requirements
- R1: After reset the settled value is X, no events are pending, and head_vld and res_vld are low. Values are encoded as 2'b00 = logic 0, 2'b11 = logic 1 and 2'b10 = X.
- R2: With no events pending, a new event is kept only when its value differs from the settled value (cur_val). Otherwise it is discarded.
- R3: The event time is ins_time + prop_dly. The verdict (res_vld, res_kept, res_removed, res_ovfl) is registered and appears in the clock cycle after the request.
- R4: An event whose time is at or after the last pending event is kept only if its value differs from that last event. Otherwise it is discarded.
- R5: An event earlier than every pending event goes to the head. If the old head carries the same value, the old head is removed (res_removed=1) and the count does not change.
- R6: An event between two pending events is discarded if its value equals the earlier neighbour. Otherwise it is kept, and a later neighbour with the same value is removed (res_removed=1).
- R7: Take an event that falls after the last pending event. If it lies less than inert_dly after that last event and returns the net to the value that held before it, the last pending event is cancelled (res_removed=1) and the new event is discarded (res_kept=0). Spacing at or above inert_dly keeps the event under R4.
- R8: An insert that would be kept while all NSLOT slots are full is dropped, res_ovfl=1 is reported, and the list is left unchanged.
- R9: head_vld is high exactly when at least one event is pending and now_time equals the head event's time. head_time and head_val show the head event.
- R10: A pop while head_vld is high loads the head value into cur_val and moves the remaining events up by one, all at one clock edge. Insert and pop are never asserted in the same cycle.
- R11: Pending events always stay in nondecreasing time order, and adjacent pending events always carry different values, so pops release them in time order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_time | input | TIME_W | Global simulation time |
| prop_dly | input | DLY_W | Propagation delay added to each request |
| inert_dly | input | DLY_W | Inertial pulse-rejection window, 0 disables |
| ins_req | input | 1 | Insert request strobe |
| ins_time | input | TIME_W | Evaluation time of the request |
| ins_val | input | 2 | Requested new value |
| pop | input | 1 | Release the head event |
| res_vld | output | 1 | Verdict for last cycle's request is valid |
| res_kept | output | 1 | Request stored in the list |
| res_removed | output | 1 | A pending event was removed as obsolete or cancelled |
| res_ovfl | output | 1 | Request dropped because the list was full |
| head_vld | output | 1 | Head event is due at now_time |
| head_time | output | TIME_W | Time of the head event |
| head_val | output | 2 | Value of the head event |
| cur_val | output | 2 | Settled value of the net |
| pend_cnt | output | CNT_W | Number of pending events |

## Verification
The hardest state to reach is an insert that lands between two pending events whose later neighbour already carries the requested value. A close second is the inertial cancel, which needs a particular three-value history. The bench builds each pending list on purpose through a sequence of kept inserts. It changes prop_dly between requests to place an event ahead of the current head. Each list is then drained through pops at chosen now_time values, so that head times and values show what was replaced or cancelled.

// File: rtl/evf_pkg.sv
package evf_pkg;

    typedef logic [1:0] lval_t;

    localparam lval_t LV_0 = 2'b00;
    localparam lval_t LV_1 = 2'b11;
    localparam lval_t LV_X = 2'b10;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_INSERT,
        OP_REPLACE,
        OP_DROP_LAST,
        OP_POP
    } slot_op_e;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_PARTIAL,
        ST_FULL
    } occ_e;

    typedef enum logic [1:0] {
        PL_EMPTY,
        PL_HEAD,
        PL_MID,
        PL_TAIL
    } place_e;

endpackage

// File: rtl/evf_slot_store.sv
module evf_slot_store
    import evf_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int TIME_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_op_e          op,
    input  logic [CNT_W-1:0]  pos,
    input  logic [TIME_W-1:0] new_t,
    input  lval_t             new_v,
    output logic [TIME_W-1:0] slot_t [NSLOT],
    output lval_t             slot_v [NSLOT],
    output logic [CNT_W-1:0]  cnt
);

    genvar gi;
    generate
        for (gi = 0; gi < NSLOT; gi++) begin : g_slot
            logic [TIME_W-1:0] up_t;
            lval_t             up_v;
            logic [TIME_W-1:0] dn_t;
            lval_t             dn_v;

            if (gi == 0) begin : g_first
                assign up_t = '0;
                assign up_v = LV_X;
            end else begin : g_rest
                assign up_t = slot_t[gi-1];
                assign up_v = slot_v[gi-1];
            end

            if (gi == NSLOT - 1) begin : g_last
                assign dn_t = slot_t[gi];
                assign dn_v = slot_v[gi];
            end else begin : g_inner
                assign dn_t = slot_t[gi+1];
                assign dn_v = slot_v[gi+1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_t[gi] <= '0;
                    slot_v[gi] <= LV_X;
                end else begin
                    unique case (op)
                        OP_INSERT: begin
                            if (pos == CNT_W'(gi)) begin
                                slot_t[gi] <= new_t;
                                slot_v[gi] <= new_v;
                            end else if (pos < CNT_W'(gi)) begin
                                slot_t[gi] <= up_t;
                                slot_v[gi] <= up_v;
                            end
                        end
                        OP_REPLACE: begin
                            if (pos == CNT_W'(gi)) begin
                                slot_t[gi] <= new_t;
                                slot_v[gi] <= new_v;
                            end
                        end
                        OP_POP: begin
                            slot_t[gi] <= dn_t;
                            slot_v[gi] <= dn_v;
                        end
                        default: ;
                    endcase
                end
            end

            if (gi < NSLOT - 1) begin : g_order_chk
                // R11
                sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (cnt > CNT_W'(gi + 1)) |-> (slot_t[gi] <= slot_t[gi+1]));
                // R11
                adjacent_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (cnt > CNT_W'(gi + 1)) |-> (slot_v[gi] != slot_v[gi+1]));
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (op)
                OP_INSERT:            cnt <= cnt + CNT_W'(1);
                OP_DROP_LAST, OP_POP: cnt <= cnt - CNT_W'(1);
                default: ;
            endcase
        end
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(NSLOT));

endmodule

// File: rtl/evf_classify.sv
module evf_classify
    import evf_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int TIME_W = 16,
    parameter int DLY_W  = 8,
    parameter int CNT_W  = 2
) (
    input  logic              req,
    input  logic [TIME_W-1:0] new_t,
    input  lval_t             new_v,
    input  lval_t             cur_v,
    input  logic [DLY_W-1:0]  inert,
    input  logic [TIME_W-1:0] slot_t [NSLOT],
    input  lval_t             slot_v [NSLOT],
    input  logic [CNT_W-1:0]  cnt,
    output slot_op_e          op,
    output logic [CNT_W-1:0]  pos,
    output logic              kept,
    output logic              removed,
    output logic              ovfl
);

    logic [CNT_W-1:0]  p;
    logic [TIME_W-1:0] last_t;
    lval_t             last_v;
    lval_t             prior_v;
    lval_t             before_v;
    lval_t             after_v;
    logic [TIME_W-1:0] gap;
    logic              full;
    logic              short_gap;
    place_e            place;

    // Position: number of pending events at or before the new time.
    always_comb begin
        p        = '0;
        last_t   = '0;
        last_v   = LV_X;
        prior_v  = cur_v;
        before_v = LV_X;
        after_v  = LV_X;
        for (int i = 0; i < NSLOT; i++) begin
            if (CNT_W'(i) < cnt && slot_t[i] <= new_t) begin
                p = p + CNT_W'(1);
            end
        end
        for (int i = 0; i < NSLOT; i++) begin
            if (CNT_W'(i + 1) == cnt) begin
                last_t = slot_t[i];
                last_v = slot_v[i];
            end
            if (CNT_W'(i + 2) == cnt) begin
                prior_v = slot_v[i];
            end
            if (CNT_W'(i + 1) == p) begin
                before_v = slot_v[i];
            end
            if (CNT_W'(i) == p) begin
                after_v = slot_v[i];
            end
        end
    end

    assign full      = (cnt == CNT_W'(NSLOT));
    assign gap       = new_t - last_t;
    assign short_gap = (gap < TIME_W'(inert));

    always_comb begin
        if (cnt == '0)     place = PL_EMPTY;
        else if (p == cnt) place = PL_TAIL;
        else if (p == '0)  place = PL_HEAD;
        else               place = PL_MID;
    end

    always_comb begin
        op      = OP_NONE;
        pos     = '0;
        kept    = 1'b0;
        removed = 1'b0;
        ovfl    = 1'b0;
        if (req) begin
            unique case (place)
                PL_EMPTY: begin
                    if (new_v != cur_v) begin
                        op   = OP_INSERT;
                        kept = 1'b1;
                    end
                end
                PL_TAIL: begin
                    if (short_gap && new_v == prior_v) begin
                        op      = OP_DROP_LAST;
                        removed = 1'b1;
                    end else if (new_v != last_v) begin
                        if (full) begin
                            ovfl = 1'b1;
                        end else begin
                            op   = OP_INSERT;
                            pos  = p;
                            kept = 1'b1;
                        end
                    end
                end
                PL_HEAD: begin
                    if (after_v == new_v) begin
                        op      = OP_REPLACE;
                        kept    = 1'b1;
                        removed = 1'b1;
                    end else if (full) begin
                        ovfl = 1'b1;
                    end else begin
                        op   = OP_INSERT;
                        kept = 1'b1;
                    end
                end
                PL_MID: begin
                    if (new_v == before_v) begin
                        op = OP_NONE;
                    end else if (after_v == new_v) begin
                        op      = OP_REPLACE;
                        pos     = p;
                        kept    = 1'b1;
                        removed = 1'b1;
                    end else if (full) begin
                        ovfl = 1'b1;
                    end else begin
                        op   = OP_INSERT;
                        pos  = p;
                        kept = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/evf_net_filter.sv
module evf_net_filter
    import evf_pkg::*;
#(
    parameter int  NSLOT  = 3,
    parameter int  TIME_W = 16,
    parameter int  DLY_W  = 8,
    localparam int CNT_W  = $clog2(NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_time,
    input  logic [DLY_W-1:0]  prop_dly,
    input  logic [DLY_W-1:0]  inert_dly,
    input  logic              ins_req,
    input  logic [TIME_W-1:0] ins_time,
    input  logic [1:0]        ins_val,
    input  logic              pop,
    output logic              res_vld,
    output logic              res_kept,
    output logic              res_removed,
    output logic              res_ovfl,
    output logic              head_vld,
    output logic [TIME_W-1:0] head_time,
    output logic [1:0]        head_val,
    output logic [1:0]        cur_val,
    output logic [CNT_W-1:0]  pend_cnt
);

    logic [TIME_W-1:0] slot_t [NSLOT];
    lval_t             slot_v [NSLOT];
    logic [CNT_W-1:0]  cnt;
    logic [TIME_W-1:0] ev_t;
    slot_op_e          cls_op;
    slot_op_e          op;
    logic [CNT_W-1:0]  cls_pos;
    logic              cls_kept;
    logic              cls_removed;
    logic              cls_ovfl;
    logic              pop_go;
    occ_e              state;
    occ_e              nxt;

    assign ev_t   = ins_time + TIME_W'(prop_dly);
    assign pop_go = pop && head_vld && !ins_req;
    assign op     = ins_req ? cls_op : (pop_go ? OP_POP : OP_NONE);

    evf_classify #(
        .NSLOT (NSLOT),
        .TIME_W(TIME_W),
        .DLY_W (DLY_W),
        .CNT_W (CNT_W)
    ) i_classify (
        .req    (ins_req),
        .new_t  (ev_t),
        .new_v  (ins_val),
        .cur_v  (cur_val),
        .inert  (inert_dly),
        .slot_t (slot_t),
        .slot_v (slot_v),
        .cnt    (cnt),
        .op     (cls_op),
        .pos    (cls_pos),
        .kept   (cls_kept),
        .removed(cls_removed),
        .ovfl   (cls_ovfl)
    );

    evf_slot_store #(
        .NSLOT (NSLOT),
        .TIME_W(TIME_W),
        .CNT_W (CNT_W)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .pos   (cls_pos),
        .new_t (ev_t),
        .new_v (ins_val),
        .slot_t(slot_t),
        .slot_v(slot_v),
        .cnt   (cnt)
    );

    // Occupancy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (op == OP_INSERT) nxt = (NSLOT == 1) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (op == OP_INSERT && cnt == CNT_W'(NSLOT - 1))
                    nxt = ST_FULL;
                else if ((op == OP_DROP_LAST || op == OP_POP) && cnt == CNT_W'(1))
                    nxt = ST_EMPTY;
            end
            ST_FULL: begin
                if (op == OP_DROP_LAST || op == OP_POP)
                    nxt = (NSLOT == 1) ? ST_EMPTY : ST_PARTIAL;
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    // Registered outputs: verdict and settled value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vld     <= 1'b0;
            res_kept    <= 1'b0;
            res_removed <= 1'b0;
            res_ovfl    <= 1'b0;
            cur_val     <= LV_X;
        end else begin
            res_vld     <= ins_req;
            res_kept    <= cls_kept;
            res_removed <= cls_removed;
            res_ovfl    <= cls_ovfl;
            if (pop_go) cur_val <= slot_v[0];
        end
    end

    always_comb begin
        head_vld  = (state != ST_EMPTY) && (slot_t[0] == now_time);
        head_time = slot_t[0];
        head_val  = slot_v[0];
        pend_cnt  = cnt;
    end

    // R1
    occ_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_EMPTY) == (cnt == '0)) && ((state == ST_FULL) == (cnt == CNT_W'(NSLOT))));

    // R3
    res_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(ins_req));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_ovfl |-> (cnt == CNT_W'(NSLOT)) && (cnt == $past(cnt)));

    // R7
    cancel_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_removed && !res_kept) |-> (cnt == $past(cnt) - CNT_W'(1)));

    // R10
    pop_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_go |=> (cur_val == $past(slot_v[0])));

    // R10
    ins_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_req && pop));

endmodule

// File: tb/test_evf_net_filter.sv
module test_evf_net_filter;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] V0 = 2'b00;
    localparam logic [1:0] V1 = 2'b11;
    localparam logic [1:0] VX = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] now_time = '0;
    logic [7:0]  prop_dly = '0;
    logic [7:0]  inert_dly = '0;
    logic        ins_req = 1'b0;
    logic [15:0] ins_time = '0;
    logic [1:0]  ins_val = V0;
    logic        pop = 1'b0;
    logic        res_vld, res_kept, res_removed, res_ovfl, head_vld;
    logic [15:0] head_time;
    logic [1:0]  head_val, cur_val, pend_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    evf_net_filter i_evf_net_filter (
        .clk(clk), .rst_n(rst_n), .now_time(now_time), .prop_dly(prop_dly),
        .inert_dly(inert_dly), .ins_req(ins_req), .ins_time(ins_time),
        .ins_val(ins_val), .pop(pop), .res_vld(res_vld), .res_kept(res_kept),
        .res_removed(res_removed), .res_ovfl(res_ovfl), .head_vld(head_vld),
        .head_time(head_time), .head_val(head_val), .cur_val(cur_val),
        .pend_cnt(pend_cnt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic ins(input int t, input logic [1:0] v);
        @(negedge clk);
        ins_time = 16'(t);
        ins_val  = v;
        ins_req  = 1'b1;
        @(negedge clk);
        ins_req  = 1'b0;
    endtask

    task automatic verdict(input string req, input int kept, input int removed,
                           input int ovfl, input int cnt);
        chk(req, "res_vld", int'(res_vld), 1);
        chk(req, "res_kept", int'(res_kept), kept);
        chk(req, "res_removed", int'(res_removed), removed);
        chk(req, "res_ovfl", int'(res_ovfl), ovfl);
        chk(req, "pend_cnt", int'(pend_cnt), cnt);
    endtask

    task automatic pop_at(input string req, input int t, input logic [1:0] v, input int cnt_after);
        @(negedge clk);
        now_time = 16'(t);
        #1;
        chk(req, "head_vld", int'(head_vld), 1);
        chk(req, "head_time", int'(head_time), t);
        chk(req, "head_val", int'(head_val), int'(v));
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk("R10", "cur_val after pop", int'(cur_val), int'(v));
        chk("R10", "pend_cnt after pop", int'(pend_cnt), cnt_after);
    endtask

    task automatic t_reset;
        chk("R1", "cur_val", int'(cur_val), int'(VX));
        chk("R1", "pend_cnt", int'(pend_cnt), 0);
        chk("R1", "head_vld", int'(head_vld), 0);
        chk("R1", "res_vld", int'(res_vld), 0);
    endtask

    task automatic t_empty;
        prop_dly = 8'd5;
        ins(0, VX);
        verdict("R2", 0, 0, 0, 0);
        ins(0, V0);
        verdict("R2", 1, 0, 0, 1);
        // R3: event time is 0 + 5
        now_time = 16'd5;
        #1;
        chk("R3", "head_time", int'(head_time), 5);
        chk("R3", "head_vld", int'(head_vld), 1);
        @(negedge clk);
        chk("R3", "res_vld drops without request", int'(res_vld), 0);
    endtask

    task automatic t_tail;
        ins(10, V0);
        verdict("R4", 0, 0, 0, 1);
        ins(10, V1);
        verdict("R4", 1, 0, 0, 2);
    endtask

    task automatic t_head;
        prop_dly = 8'd1;
        ins(1, V0);                 // time 2, same value as head 0@5
        verdict("R5", 1, 1, 0, 2);
        @(negedge clk);
        now_time = 16'd2;
        #1;
        chk("R5", "head moved to 2", int'(head_vld), 1);
        prop_dly = 8'd0;
        ins(1, V1);                 // time 1, new head
        verdict("R5", 1, 0, 0, 3);
    endtask

    task automatic t_overflow_and_drain;
        ins(20, V0);
        verdict("R8", 0, 0, 1, 3);
        @(negedge clk);
        now_time = 16'd0;
        #1;
        chk("R9", "head_vld when time differs", int'(head_vld), 0);
        pop_at("R11", 1, V1, 2);
        pop_at("R11", 2, V0, 1);
        pop_at("R11", 15, V1, 0);
        #1;
        chk("R8", "dropped event absent", int'(head_vld), 0);
    endtask

    task automatic t_mid;
        ins(30, V1);                // equals cur_val 1
        verdict("R2", 0, 0, 0, 0);
        ins(10, V0);
        verdict("R6", 1, 0, 0, 1);
        ins(20, V1);
        verdict("R6", 1, 0, 0, 2);
        ins(15, V0);
        verdict("R6", 0, 0, 0, 2);
        ins(15, V1);
        verdict("R6", 1, 1, 0, 2);
        pop_at("R6", 10, V0, 1);
        pop_at("R6", 15, V1, 0);
    endtask

    task automatic t_inertial;
        inert_dly = 8'd3;
        ins(1, V0);
        verdict("R7", 1, 0, 0, 1);
        ins(5, V1);                 // gap 4, not below 3
        verdict("R7", 1, 0, 0, 2);
        ins(6, V0);                 // gap 1, returns to 0
        verdict("R7", 0, 1, 0, 1);
        ins(20, V1);
        verdict("R7", 1, 0, 0, 2);
        pop_at("R7", 1, V0, 1);
        pop_at("R7", 20, V1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_empty();
        t_tail();
        t_head();
        t_overflow_and_drain();
        t_mid();
        t_inertial();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule